// File: doc/BRIEF.md
# Packet Fragment Ingress Processor

This block receives packet fragments from a single ingress physical port, one beat per cycle. Each beat carries a logical port number, start and end of packet flags, an address-parity error flag, a data-parity error flag, a byte count and the data word. The block keeps a small descriptor for every logical port: a state, the segment currently being filled, the number of bytes already in that segment, the running packet length and a sticky data-parity flag.

A beat that opens a packet asks an external segment pool for a buffer segment in the same cycle. The pool grants it and returns the segment number, or it refuses. On a grant, the beat's bytes are written into the segment at the current fill offset. A segment is handed to the egress queue when its fill reaches the programmed fragment size, or when the packet ends. A filled segment that is not the last one of its packet makes the next beat of that logical port ask for a fresh segment. At the end of a packet the total length is compared with the programmed minimum and maximum. Flushes and length violations leave the block as single-cycle coded event pulses for an external counter block.

All write, queue and event outputs appear one clock after the beat that causes them. The segment request and its grant are combinational within the beat's own cycle.

Top module: `frag_ingress`

## Requirements
- R1: After reset every output is low and every logical port is idle, so a beat without start of packet on any port produces no output.
- R2: A beat with the address-parity flag set produces, one cycle later, an event with code 0 (flush) and no write and no queue entry. It raises no segment request and leaves every descriptor unchanged.
- R3: A beat with start of packet raises `seg_req` in the same cycle, with `seg_req_lp` equal to its logical port. On a grant, its data is written at offset 0 of the granted segment, and the packet length restarts from this beat's byte count.
- R4: When a segment request is refused, one cycle later there is a flush event (code 0) and no write. Later beats of that packet on that logical port are discarded silently, up to and including its end of packet. The next start of packet is processed normally.
- R5: Every accepted beat produces, one cycle later, a write whose segment is the port's current segment, whose offset is the byte count already in that segment, and whose byte count and data are those of the beat.
- R6: When a segment's fill becomes greater than or equal to `cfg_frag_size` on a beat without end of packet, a queue entry with `q_eop`=0 and the fill as length is pushed. The next beat of that port raises `seg_req` and starts a new segment at offset 0.
- R7: A beat with end of packet pushes exactly one queue entry with `q_eop`=1. This holds even when the same beat also fills the segment to `cfg_frag_size`.
- R8: At end of packet only, a total length below `cfg_min_len` gives an event with code 1 (too short), and a total above `cfg_max_len` gives an event with code 2 (too long). The event appears in the same cycle as the closing queue entry.
- R9: `q_err` is the OR of the data-parity flags of all beats written into that segment.
- R10: A beat without start of packet arriving on an idle logical port produces no write, no queue entry, no event and no segment request.
- R11: Events are single-cycle pulses with at most one event per cycle. A cycle without a valid beat is followed by a cycle with no write, no queue entry and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fragment beat present |
| in_lp | input | LP_W (6) | Logical port of the beat |
| in_sop | input | 1 | Beat opens a packet |
| in_eop | input | 1 | Beat closes a packet |
| in_addr_perr | input | 1 | Address parity error on the beat |
| in_data_perr | input | 1 | Data parity error on the beat |
| in_bytes | input | CNT_W (4) | Valid bytes in the beat |
| in_data | input | DATA_W (64) | Beat data |
| cfg_frag_size | input | SLEN_W (12) | Segment fill that closes a segment |
| cfg_min_len | input | PLEN_W (16) | Minimum legal packet length |
| cfg_max_len | input | PLEN_W (16) | Maximum legal packet length |
| seg_req | output | 1 | Segment request to the pool (same cycle) |
| seg_req_lp | output | LP_W (6) | Logical port requesting |
| seg_grant | input | 1 | Pool accepts the request |
| seg_grant_id | input | SEG_W (9) | Granted segment number |
| wr_valid | output | 1 | Segment write |
| wr_seg | output | SEG_W (9) | Segment written |
| wr_off | output | SLEN_W (12) | Byte offset inside the segment |
| wr_bytes | output | CNT_W (4) | Bytes written |
| wr_data | output | DATA_W (64) | Data written |
| q_valid | output | 1 | Egress queue push |
| q_seg | output | SEG_W (9) | Segment queued |
| q_lp | output | LP_W (6) | Logical port of the segment |
| q_len | output | SLEN_W (12) | Bytes in the segment |
| q_eop | output | 1 | Segment ends its packet |
| q_err | output | 1 | Data parity error seen in the segment |
| ev_valid | output | 1 | Event pulse |
| ev_code | output | 2 | 0 flush, 1 too short, 2 too long |
| ev_lp | output | LP_W (6) | Logical port of the event |

## Verification
Two things can meet on one beat: a segment reaching its fragment size and the packet ending. The bench provokes this on purpose with four 8-byte beats against a 32-byte fragment size. It also provokes it at random with beats of varying size. The bench expects a single queue entry marked as end of packet, together with any length event in that same cycle. A refused request on a beat that both opens and closes a packet is the second collision, and it must yield a flush and leave the port idle.

// File: rtl/frag_ingress_pkg.sv
package frag_ingress_pkg;
  typedef enum logic [1:0] {
    DS_IDLE   = 2'd0,
    DS_ACTIVE = 2'd1,
    DS_NEED   = 2'd2,
    DS_DROP   = 2'd3
  } desc_state_e;

  localparam logic [1:0] EV_FLUSH = 2'd0;
  localparam logic [1:0] EV_SHORT = 2'd1;
  localparam logic [1:0] EV_LONG  = 2'd2;
endpackage

// File: rtl/frag_desc_table.sv
module frag_desc_table
  import frag_ingress_pkg::*;
#(
  parameter int LP_W   = 6,
  parameter int SEG_W  = 9,
  parameter int SLEN_W = 12,
  parameter int PLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LP_W-1:0]   rd_lp,
  output desc_state_e       rd_state,
  output logic [SEG_W-1:0]  rd_seg,
  output logic [SLEN_W-1:0] rd_slen,
  output logic [PLEN_W-1:0] rd_plen,
  output logic              rd_perr,
  input  logic              we,
  input  logic [LP_W-1:0]   wr_lp,
  input  desc_state_e       wr_state,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic [SLEN_W-1:0] wr_slen,
  input  logic [PLEN_W-1:0] wr_plen,
  input  logic              wr_perr
);
  localparam int DEPTH = 1 << LP_W;

  desc_state_e       st_q   [DEPTH];
  logic [SEG_W-1:0]  seg_q  [DEPTH];
  logic [SLEN_W-1:0] slen_q [DEPTH];
  logic [PLEN_W-1:0] plen_q [DEPTH];
  logic              perr_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]   <= DS_IDLE;
        seg_q[i]  <= '0;
        slen_q[i] <= '0;
        plen_q[i] <= '0;
        perr_q[i] <= 1'b0;
      end
    end else if (we) begin
      st_q[wr_lp]   <= wr_state;
      seg_q[wr_lp]  <= wr_seg;
      slen_q[wr_lp] <= wr_slen;
      plen_q[wr_lp] <= wr_plen;
      perr_q[wr_lp] <= wr_perr;
    end
  end

  assign rd_state = st_q[rd_lp];
  assign rd_seg   = seg_q[rd_lp];
  assign rd_slen  = slen_q[rd_lp];
  assign rd_plen  = plen_q[rd_lp];
  assign rd_perr  = perr_q[rd_lp];

  // A descriptor update must never carry an unknown state (R1 idle baseline)
  p_desc_write_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$isunknown(wr_state));
endmodule

// File: rtl/frag_ctrl.sv
module frag_ctrl
  import frag_ingress_pkg::*;
#(
  parameter int LP_W   = 6,
  parameter int SEG_W  = 9,
  parameter int SLEN_W = 12,
  parameter int PLEN_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_addr_perr,
  input  logic              in_data_perr,
  input  logic [CNT_W-1:0]  in_bytes,
  input  logic [SLEN_W-1:0] cfg_frag_size,
  input  logic [PLEN_W-1:0] cfg_min_len,
  input  logic [PLEN_W-1:0] cfg_max_len,
  input  desc_state_e       rd_state,
  input  logic [SEG_W-1:0]  rd_seg,
  input  logic [SLEN_W-1:0] rd_slen,
  input  logic [PLEN_W-1:0] rd_plen,
  input  logic              rd_perr,
  input  logic              seg_grant,
  input  logic [SEG_W-1:0]  seg_grant_id,
  output logic              seg_req,
  output logic              d_we,
  output desc_state_e       d_state,
  output logic [SEG_W-1:0]  d_seg,
  output logic [SLEN_W-1:0] d_slen,
  output logic [PLEN_W-1:0] d_plen,
  output logic              d_perr,
  output logic              n_wr,
  output logic [SEG_W-1:0]  n_wr_seg,
  output logic [SLEN_W-1:0] n_wr_off,
  output logic              n_q,
  output logic [SLEN_W-1:0] n_q_len,
  output logic              n_q_eop,
  output logic              n_q_err,
  output logic              n_ev,
  output logic [1:0]        n_ev_code
);
  function automatic logic [SLEN_W-1:0] seg_add(input logic [SLEN_W-1:0] a,
                                                input logic [CNT_W-1:0]  b);
    return a + SLEN_W'(b);
  endfunction

  function automatic logic [PLEN_W-1:0] pkt_add_sat(input logic [PLEN_W-1:0] a,
                                                    input logic [CNT_W-1:0]  b);
    logic [PLEN_W:0] s;
    s = {1'b0, a} + (PLEN_W+1)'(b);
    return s[PLEN_W] ? {PLEN_W{1'b1}} : s[PLEN_W-1:0];
  endfunction

  logic              fresh, live, seg_full;
  logic [SEG_W-1:0]  use_seg;
  logic [SLEN_W-1:0] base_slen, new_slen;
  logic [PLEN_W-1:0] base_plen, new_plen;
  logic              base_perr, new_perr;
  logic              evt_flush, evt_short, evt_long;

  assign fresh     = in_sop || (rd_state == DS_NEED);
  assign live      = in_sop || (rd_state == DS_ACTIVE) || (rd_state == DS_NEED);
  assign use_seg   = fresh ? seg_grant_id : rd_seg;
  assign base_slen = fresh ? '0 : rd_slen;
  assign base_plen = in_sop ? '0 : rd_plen;
  assign base_perr = fresh ? 1'b0 : rd_perr;
  assign new_slen  = seg_add(base_slen, in_bytes);
  assign new_plen  = pkt_add_sat(base_plen, in_bytes);
  assign new_perr  = base_perr | in_data_perr;
  assign seg_full  = new_slen >= cfg_frag_size;

  always_comb begin
    seg_req   = 1'b0;
    d_we      = 1'b0;
    d_state   = rd_state;
    d_seg     = use_seg;
    d_slen    = new_slen;
    d_plen    = new_plen;
    d_perr    = new_perr;
    n_wr      = 1'b0;
    n_q       = 1'b0;
    evt_flush = 1'b0;
    evt_short = 1'b0;
    evt_long  = 1'b0;
    if (in_valid && in_addr_perr) begin
      evt_flush = 1'b1;
    end else if (in_valid) begin
      if (!live) begin
        if (rd_state == DS_DROP && in_eop) begin
          d_we    = 1'b1;
          d_state = DS_IDLE;
          d_seg   = rd_seg;
          d_slen  = rd_slen;
          d_plen  = rd_plen;
          d_perr  = rd_perr;
        end
      end else begin
        seg_req = fresh;
        d_we    = 1'b1;
        if (fresh && !seg_grant) begin
          evt_flush = 1'b1;
          d_state   = in_eop ? DS_IDLE : DS_DROP;
        end else begin
          n_wr = 1'b1;
          n_q  = seg_full || in_eop;
          if (in_eop) begin
            evt_short = new_plen < cfg_min_len;
            evt_long  = new_plen > cfg_max_len;
            d_state   = DS_IDLE;
          end else if (seg_full) begin
            d_state = DS_NEED;
          end else begin
            d_state = DS_ACTIVE;
          end
        end
      end
    end
  end

  assign n_wr_seg  = use_seg;
  assign n_wr_off  = base_slen;
  assign n_q_len   = new_slen;
  assign n_q_eop   = in_eop;
  assign n_q_err   = new_perr;
  assign n_ev      = evt_flush | evt_short | evt_long;
  assign n_ev_code = evt_flush ? EV_FLUSH : (evt_short ? EV_SHORT : EV_LONG);

  p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_flush, evt_short, evt_long}));

  p_req_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_req |-> in_valid && !in_addr_perr);

  p_flush_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flush |-> !n_wr && !n_q);
endmodule

// File: rtl/frag_out_reg.sv
module frag_out_reg #(
  parameter int LP_W   = 6,
  parameter int SEG_W  = 9,
  parameter int SLEN_W = 12,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              n_wr,
  input  logic [SEG_W-1:0]  n_wr_seg,
  input  logic [SLEN_W-1:0] n_wr_off,
  input  logic [CNT_W-1:0]  n_wr_bytes,
  input  logic [DATA_W-1:0] n_wr_data,
  input  logic              n_q,
  input  logic [LP_W-1:0]   n_lp,
  input  logic [SLEN_W-1:0] n_q_len,
  input  logic              n_q_eop,
  input  logic              n_q_err,
  input  logic              n_ev,
  input  logic [1:0]        n_ev_code,
  output logic              wr_valid,
  output logic [SEG_W-1:0]  wr_seg,
  output logic [SLEN_W-1:0] wr_off,
  output logic [CNT_W-1:0]  wr_bytes,
  output logic [DATA_W-1:0] wr_data,
  output logic              q_valid,
  output logic [SEG_W-1:0]  q_seg,
  output logic [LP_W-1:0]   q_lp,
  output logic [SLEN_W-1:0] q_len,
  output logic              q_eop,
  output logic              q_err,
  output logic              ev_valid,
  output logic [1:0]        ev_code,
  output logic [LP_W-1:0]   ev_lp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_seg   <= '0;
      wr_off   <= '0;
      wr_bytes <= '0;
      wr_data  <= '0;
      q_valid  <= 1'b0;
      q_seg    <= '0;
      q_lp     <= '0;
      q_len    <= '0;
      q_eop    <= 1'b0;
      q_err    <= 1'b0;
      ev_valid <= 1'b0;
      ev_code  <= '0;
      ev_lp    <= '0;
    end else begin
      wr_valid <= n_wr;
      wr_seg   <= n_wr_seg;
      wr_off   <= n_wr_off;
      wr_bytes <= n_wr_bytes;
      wr_data  <= n_wr_data;
      q_valid  <= n_q;
      q_seg    <= n_wr_seg;
      q_lp     <= n_lp;
      q_len    <= n_q_len;
      q_eop    <= n_q_eop;
      q_err    <= n_q_err;
      ev_valid <= n_ev;
      ev_code  <= n_ev_code;
      ev_lp    <= n_lp;
    end
  end

  // A queued segment is always one that was written in the same beat (R5)
  p_queue_has_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> wr_valid && wr_seg == q_seg);
endmodule

// File: rtl/frag_ingress.sv
module frag_ingress
  import frag_ingress_pkg::*;
#(
  parameter int LP_W       = 6,
  parameter int SEG_W      = 9,
  parameter int SLEN_W     = 12,
  parameter int PLEN_W     = 16,
  parameter int BEAT_BYTES = 8,
  localparam int CNT_W     = $clog2(BEAT_BYTES + 1),
  localparam int DATA_W    = BEAT_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [LP_W-1:0]   in_lp,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_addr_perr,
  input  logic              in_data_perr,
  input  logic [CNT_W-1:0]  in_bytes,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SLEN_W-1:0] cfg_frag_size,
  input  logic [PLEN_W-1:0] cfg_min_len,
  input  logic [PLEN_W-1:0] cfg_max_len,
  output logic              seg_req,
  output logic [LP_W-1:0]   seg_req_lp,
  input  logic              seg_grant,
  input  logic [SEG_W-1:0]  seg_grant_id,
  output logic              wr_valid,
  output logic [SEG_W-1:0]  wr_seg,
  output logic [SLEN_W-1:0] wr_off,
  output logic [CNT_W-1:0]  wr_bytes,
  output logic [DATA_W-1:0] wr_data,
  output logic              q_valid,
  output logic [SEG_W-1:0]  q_seg,
  output logic [LP_W-1:0]   q_lp,
  output logic [SLEN_W-1:0] q_len,
  output logic              q_eop,
  output logic              q_err,
  output logic              ev_valid,
  output logic [1:0]        ev_code,
  output logic [LP_W-1:0]   ev_lp
);
  desc_state_e       rd_state, d_state;
  logic [SEG_W-1:0]  rd_seg, d_seg, n_wr_seg;
  logic [SLEN_W-1:0] rd_slen, d_slen, n_wr_off, n_q_len;
  logic [PLEN_W-1:0] rd_plen, d_plen;
  logic              rd_perr, d_perr, d_we;
  logic              n_wr, n_q, n_q_eop, n_q_err, n_ev;
  logic [1:0]        n_ev_code;

  assign seg_req_lp = in_lp;

  frag_desc_table #(.LP_W(LP_W), .SEG_W(SEG_W), .SLEN_W(SLEN_W), .PLEN_W(PLEN_W)) u_table (
    .clk(clk), .rst_n(rst_n), .rd_lp(in_lp),
    .rd_state(rd_state), .rd_seg(rd_seg), .rd_slen(rd_slen), .rd_plen(rd_plen), .rd_perr(rd_perr),
    .we(d_we), .wr_lp(in_lp), .wr_state(d_state), .wr_seg(d_seg), .wr_slen(d_slen),
    .wr_plen(d_plen), .wr_perr(d_perr)
  );

  frag_ctrl #(.LP_W(LP_W), .SEG_W(SEG_W), .SLEN_W(SLEN_W), .PLEN_W(PLEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_addr_perr(in_addr_perr), .in_data_perr(in_data_perr), .in_bytes(in_bytes),
    .cfg_frag_size(cfg_frag_size), .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len),
    .rd_state(rd_state), .rd_seg(rd_seg), .rd_slen(rd_slen), .rd_plen(rd_plen), .rd_perr(rd_perr),
    .seg_grant(seg_grant), .seg_grant_id(seg_grant_id), .seg_req(seg_req),
    .d_we(d_we), .d_state(d_state), .d_seg(d_seg), .d_slen(d_slen), .d_plen(d_plen), .d_perr(d_perr),
    .n_wr(n_wr), .n_wr_seg(n_wr_seg), .n_wr_off(n_wr_off), .n_q(n_q), .n_q_len(n_q_len),
    .n_q_eop(n_q_eop), .n_q_err(n_q_err), .n_ev(n_ev), .n_ev_code(n_ev_code)
  );

  frag_out_reg #(.LP_W(LP_W), .SEG_W(SEG_W), .SLEN_W(SLEN_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .n_wr(n_wr), .n_wr_seg(n_wr_seg), .n_wr_off(n_wr_off),
    .n_wr_bytes(in_bytes), .n_wr_data(in_data), .n_q(n_q), .n_lp(in_lp), .n_q_len(n_q_len),
    .n_q_eop(n_q_eop), .n_q_err(n_q_err), .n_ev(n_ev), .n_ev_code(n_ev_code),
    .wr_valid(wr_valid), .wr_seg(wr_seg), .wr_off(wr_off), .wr_bytes(wr_bytes), .wr_data(wr_data),
    .q_valid(q_valid), .q_seg(q_seg), .q_lp(q_lp), .q_len(q_len), .q_eop(q_eop), .q_err(q_err),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_lp(ev_lp)
  );

  p_aperr_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_addr_perr |=> ev_valid && ev_code == EV_FLUSH && !wr_valid && !q_valid);

  p_grant_offset0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_req && seg_grant |=> wr_valid && wr_seg == $past(seg_grant_id) && wr_off == '0);

  p_reject_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_req && !seg_grant |=> ev_valid && ev_code == EV_FLUSH && !wr_valid);

  p_full_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_eop && !in_addr_perr && (seg_req ? seg_grant : 1'b1) && n_q
      |=> q_valid && !q_eop && q_len >= $past(cfg_frag_size));

  p_len_ev_at_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_code != EV_FLUSH |-> q_valid && q_eop);

  p_quiet_after_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_valid && !q_valid && !ev_valid);
endmodule

// File: tb/frag_ingress_tb.sv
module frag_ingress_tb;
  localparam int LP_W = 6, SEG_W = 9, SLEN_W = 12, PLEN_W = 16, BEAT_BYTES = 8;
  localparam int CNT_W = 4, DATA_W = 64;
  localparam int FRAG = 32, MINL = 20, MAXL = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_addr_perr = 0, in_data_perr = 0;
  logic [LP_W-1:0] in_lp = '0;
  logic [CNT_W-1:0] in_bytes = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic [SLEN_W-1:0] cfg_frag_size = SLEN_W'(FRAG);
  logic [PLEN_W-1:0] cfg_min_len = PLEN_W'(MINL), cfg_max_len = PLEN_W'(MAXL);
  logic seg_req, seg_grant = 0;
  logic [LP_W-1:0] seg_req_lp;
  logic [SEG_W-1:0] seg_grant_id = '0;
  logic wr_valid, q_valid, q_eop, q_err, ev_valid;
  logic [SEG_W-1:0] wr_seg, q_seg;
  logic [SLEN_W-1:0] wr_off, q_len;
  logic [CNT_W-1:0] wr_bytes;
  logic [DATA_W-1:0] wr_data;
  logic [LP_W-1:0] q_lp, ev_lp;
  logic [1:0] ev_code;

  frag_ingress u_dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int m_st[64], m_seg[64], m_slen[64], m_plen[64];
  bit m_perr[64];
  bit e_req, e_wr, e_q, e_q_eop, e_q_err, e_ev;
  int e_seg, e_off, e_bytes, e_q_len, e_lp, e_code;
  logic [DATA_W-1:0] e_data;
  string tag;

  task automatic chk(string r, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d", r, what, act, exp);
    end
  endtask

  // Expected behaviour restated from the requirements; model states:
  // 0 idle, 1 filling, 2 waiting for a fresh segment, 3 discarding
  task automatic predict(bit v, int lp, bit sop, bit eop, bit ap, bit dp, int nb,
                         bit gr, int gid);
    int seg, soff, plen;
    bit perr, full;
    e_req = 0; e_wr = 0; e_q = 0; e_ev = 0; e_lp = lp; e_bytes = nb;
    tag = "R11";
    if (!v) return;
    if (ap) begin e_ev = 1; e_code = 0; tag = "R2"; return; end
    if (!(sop || m_st[lp] == 1 || m_st[lp] == 2)) begin
      tag = "R10";
      if (m_st[lp] == 3 && eop) m_st[lp] = 0;
      return;
    end
    plen = sop ? nb : m_plen[lp] + nb;
    if (sop || m_st[lp] == 2) begin
      e_req = 1;
      if (!gr) begin
        e_ev = 1; e_code = 0; tag = "R4";
        m_st[lp] = eop ? 0 : 3;
        return;
      end
      seg = gid; soff = 0; perr = 0;
    end else begin
      seg = m_seg[lp]; soff = m_slen[lp]; perr = m_perr[lp];
    end
    perr = perr | dp;
    e_wr = 1; e_seg = seg; e_off = soff; tag = "R5";
    full = (soff + nb) >= FRAG;
    if (full || eop) begin
      e_q = 1; e_q_len = soff + nb; e_q_eop = eop; e_q_err = perr;
      tag = eop ? "R7" : "R6";
    end
    if (eop) begin
      if (plen < MINL) begin e_ev = 1; e_code = 1; tag = "R8"; end
      else if (plen > MAXL) begin e_ev = 1; e_code = 2; tag = "R8"; end
      m_st[lp] = 0;
    end else m_st[lp] = full ? 2 : 1;
    m_seg[lp] = seg; m_slen[lp] = soff + nb; m_plen[lp] = plen; m_perr[lp] = perr;
  endtask

  task automatic step(bit v, int lp, bit sop, bit eop, bit ap, bit dp, int nb,
                      bit gr, int gid);
    in_valid = v; in_lp = LP_W'(lp); in_sop = sop; in_eop = eop;
    in_addr_perr = ap; in_data_perr = dp; in_bytes = CNT_W'(nb);
    in_data = {$urandom, $urandom}; seg_grant = gr; seg_grant_id = SEG_W'(gid);
    e_data = in_data;
    predict(v, lp, sop, eop, ap, dp, nb, gr, gid);
    #1;
    chk("R3", "seg_req", seg_req, e_req);
    if (e_req) chk("R3", "seg_req_lp", seg_req_lp, lp);
    @(posedge clk); @(negedge clk);
    chk(tag, "wr_valid", wr_valid, e_wr);
    if (e_wr && wr_valid) begin
      chk("R5", "wr_seg", wr_seg, e_seg);
      chk("R5", "wr_off", wr_off, e_off);
      chk("R5", "wr_bytes", wr_bytes, e_bytes);
      chk("R5", "wr_data", longint'(wr_data), longint'(e_data));
    end
    chk(tag, "q_valid", q_valid, e_q);
    if (e_q && q_valid) begin
      chk(tag, "q_seg", q_seg, e_seg);
      chk(tag, "q_lp", q_lp, e_lp);
      chk(tag, "q_len", q_len, e_q_len);
      chk(tag, "q_eop", q_eop, e_q_eop);
      chk("R9", "q_err", q_err, e_q_err);
    end
    chk(tag, "ev_valid", ev_valid, e_ev);
    if (e_ev && ev_valid) begin
      chk(tag, "ev_code", ev_code, e_code);
      chk(tag, "ev_lp", ev_lp, e_lp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) begin
      m_st[i] = 0; m_seg[i] = 0; m_slen[i] = 0; m_plen[i] = 0; m_perr[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: outputs idle after reset
    chk("R1", "reset outputs", {wr_valid, q_valid, ev_valid, seg_req}, 0);
    // R10 on a port fresh out of reset
    step(1, 5, 0, 0, 0, 0, 8, 1, 3);
    step(1, 5, 0, 1, 0, 0, 8, 1, 3);
    // single short packet: too short at EOP (R8)
    step(1, 1, 1, 1, 0, 0, 8, 1, 17);
    // address parity flush (R2)
    step(1, 2, 1, 0, 1, 0, 8, 1, 4);
    step(1, 2, 0, 0, 0, 0, 8, 1, 4);
    // refused request then discard until EOP, then recover (R4)
    step(1, 3, 1, 0, 0, 0, 8, 0, 9);
    step(1, 3, 0, 0, 0, 0, 8, 1, 9);
    step(1, 3, 0, 1, 0, 0, 8, 1, 9);
    step(1, 3, 1, 1, 0, 0, 8, 0, 9);
    step(1, 3, 1, 0, 0, 0, 8, 1, 10);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // fill and EOP on the same beat: one entry (R7), parity sticky (R9)
    step(1, 4, 1, 0, 0, 1, 8, 1, 30);
    step(1, 4, 0, 0, 0, 0, 8, 1, 0);
    step(1, 4, 0, 0, 0, 0, 8, 1, 0);
    step(1, 4, 0, 1, 0, 0, 8, 1, 0);
    // long packet across segments: refill requests (R6), too long (R8)
    for (int k = 0; k < 15; k++) step(1, 6, k == 0, k == 14, 0, 0, 8, 1, 40 + k);
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 7) != 0, $urandom_range(0, 3), $urandom_range(0, 3) == 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 19) == 0,
           $urandom_range(0, 15) == 0, $urandom_range(1, BEAT_BYTES),
           $urandom_range(0, 9) < 8, $urandom_range(0, 511));
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule